// File: doc/BRIEF.md
# Burst Gate-Drive Generator with Dead Band

This block drives both gates of a half-bridge that fires ultrasound bursts. While the burst request is held high, it produces a fixed-rate square wave with a 50% duty cycle on the high-side leg, and the complement of that wave on the low-side leg. Each transition of the pair carries a dead band, set in ticks of the fast system clock, during which neither switch conducts. Inside the block the low-side leg is built as an active-high signal. It is inverted once more before it leaves the block. As a result, at rest the high-side output is low and the low-side output is high.

A single phase counter times the pulse train. With the default settings the counter runs 20 ticks per output period, which gives 5 MHz from a 100 MHz clock. The same counter also produces a reference clock at four times the pulse rate, in phase with the transmit pulses, for a quadrature demodulator on the receive path. This reference runs continuously. A rising edge on the burst request restarts the counter, so the first pulse is always a full period and the reference clock phase is aligned to it. When the request drops, the current period runs to completion before the legs go back to rest.

Top module: `cpwm_burst_driver`

## Requirements
- R1: While reset is asserted, `pwm_hi` is 0, `pwm_lo_n` is 1 and `demod_clk` is 0.
- R2: During an active period, `pwm_hi` is 1 exactly on the period ticks t with N <= t < PERIOD_TICKS/2, where N is the dead time in effect. Ticks are numbered 0 to PERIOD_TICKS-1 and appear on the outputs one clock after the counter reaches them.
- R3: During an active period, `pwm_lo_n` is 0 exactly on the ticks t with PERIOD_TICKS/2 + N <= t, and 1 on every other tick.
- R4: `pwm_hi` = 1 and `pwm_lo_n` = 0 never occur together.
- R5: A `dead_ticks` value above DT_MAX (default 4) is treated as DT_MAX.
- R6: `dead_ticks` is sampled only when a period starts. A change in the middle of a period takes effect from the next period.
- R7: A rising edge of `burst_en` restarts the counter at tick 0 on the next clock, even if the previous burst is still finishing its period.
- R8: After `burst_en` falls, the current period runs through tick PERIOD_TICKS-1 before the outputs go idle.
- R9: When no burst is active, `pwm_hi` is 0 and `pwm_lo_n` is 1.
- R10: `demod_clk` has a period of PERIOD_TICKS/4 ticks. It is high for the first ceil(PERIOD_TICKS/8) ticks of each quarter, rises on tick 0 of every period, and runs whether or not a burst is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock; one tick of dead band per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_en | input | 1 | Burst request; the rising edge restarts the period |
| dead_ticks | input | DT_W | Requested dead band in clock ticks; saturates at DT_MAX |
| pwm_hi | output | 1 | High-side gate leg, active high, rests low |
| pwm_lo_n | output | 1 | Low-side gate leg after the final inversion, rests high |
| demod_clk | output | 1 | Reference clock at four times the pulse rate, in phase with the pulses |

## Verification
The bench builds the block with its default values: a 20-tick period, DT_MAX of 4 and a 3-bit dead-time input. With these values every input code, 0 to 7, can be swept, and each code above 4 exercises saturation. A 5-tick quarter gives an odd reference clock split of 3 high and 2 low. Within the sweep the bench also changes the dead time in the middle of a period, drops the request at an odd point inside a period, and raises it again before the trailing period has finished. Every output bit on every cycle is compared with a tick-count model.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // Limit a requested dead band to the supported maximum.
  function automatic int unsigned clamp_dead(int unsigned raw, int unsigned lim);
    return (raw > lim) ? lim : raw;
  endfunction

  // High-side leg: first half of the period minus the leading dead band.
  function automatic bit lead_high(int unsigned t, int unsigned dt, int unsigned half);
    return (t >= dt) && (t < half);
  endfunction

  // Inner low-side leg: second half of the period minus its dead band.
  function automatic bit trail_high(int unsigned t, int unsigned dt, int unsigned half);
    return t >= (half + dt);
  endfunction

  // Reference clock: high for the first ceil(qtr/2) ticks of each quarter.
  function automatic bit ref_high(int unsigned q, int unsigned qtr);
    return q < ((qtr + 1) / 2);
  endfunction

endpackage

// File: rtl/cpwm_phase_gen.sv
module cpwm_phase_gen #(
  parameter int PERIOD_TICKS = 20,
  parameter int QTR          = 5,
  parameter int CNT_W        = 5,
  parameter int QTR_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_q,
  output logic [QTR_W-1:0] qtr_q,
  output logic             period_end
);

  logic qtr_end;

  assign period_end = (cnt_q == CNT_W'(PERIOD_TICKS - 1));
  assign qtr_end    = (qtr_q == QTR_W'(QTR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      qtr_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      qtr_q <= '0;
    end else begin
      cnt_q <= period_end ? '0 : cnt_q + 1'b1;
      qtr_q <= qtr_end    ? '0 : qtr_q + 1'b1;
    end
  end

endmodule

// File: rtl/cpwm_burst_ctrl.sv
module cpwm_burst_ctrl #(
  parameter int DT_MAX = 4,
  parameter int DT_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            burst_en,
  input  logic [DT_W-1:0] dead_ticks,
  input  logic            period_end,
  output logic            rise,
  output logic            run_q,
  output logic [DT_W-1:0] dt_q
);
  import cpwm_pkg::*;

  logic en_q;
  logic load_dt;

  assign rise    = burst_en & ~en_q;
  assign load_dt = rise | period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      dt_q  <= '0;
    end else begin
      en_q <= burst_en;
      if (rise)
        run_q <= 1'b1;
      else if (period_end && !burst_en)
        run_q <= 1'b0;
      if (load_dt)
        dt_q <= DT_W'(clamp_dead(int'(dead_ticks), DT_MAX));
    end
  end

endmodule

// File: rtl/cpwm_leg_shaper.sv
module cpwm_leg_shaper #(
  parameter int PERIOD_TICKS = 20,
  parameter int QTR          = 5,
  parameter int CNT_W        = 5,
  parameter int QTR_W        = 3,
  parameter int DT_W         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [QTR_W-1:0] qtr,
  input  logic [DT_W-1:0]  dt,
  output logic             pwm_hi,
  output logic             pwm_lo_n,
  output logic             demod_clk
);
  import cpwm_pkg::*;

  localparam int HALF = PERIOD_TICKS / 2;

  logic lead_d;
  logic trail_d;
  logic ref_d;
  logic inner_q;

  assign lead_d  = run & lead_high(int'(cnt), int'(dt), HALF);
  assign trail_d = run & trail_high(int'(cnt), int'(dt), HALF);
  assign ref_d   = ref_high(int'(qtr), QTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_hi    <= 1'b0;
      inner_q   <= 1'b0;
      demod_clk <= 1'b0;
    end else begin
      pwm_hi    <= lead_d;
      inner_q   <= trail_d;
      demod_clk <= ref_d;
    end
  end

  // Final inversion of the low-side leg after dead-band insertion.
  assign pwm_lo_n = ~inner_q;

endmodule

// File: rtl/cpwm_burst_driver.sv
module cpwm_burst_driver #(
  parameter int PERIOD_TICKS = 20,
  parameter int DT_MAX       = 4,
  parameter int DT_W         = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            burst_en,
  input  logic [DT_W-1:0] dead_ticks,
  output logic            pwm_hi,
  output logic            pwm_lo_n,
  output logic            demod_clk
);

  localparam int QTR   = PERIOD_TICKS / 4;
  localparam int CNT_W = $clog2(PERIOD_TICKS);
  localparam int QTR_W = (QTR > 1) ? $clog2(QTR) : 1;

  logic             rise;
  logic             run_q;
  logic             period_end;
  logic [CNT_W-1:0] cnt_q;
  logic [QTR_W-1:0] qtr_q;
  logic [DT_W-1:0]  dt_q;

  cpwm_burst_ctrl #(
    .DT_MAX (DT_MAX),
    .DT_W   (DT_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_en   (burst_en),
    .dead_ticks (dead_ticks),
    .period_end (period_end),
    .rise       (rise),
    .run_q      (run_q),
    .dt_q       (dt_q)
  );

  cpwm_phase_gen #(
    .PERIOD_TICKS (PERIOD_TICKS),
    .QTR          (QTR),
    .CNT_W        (CNT_W),
    .QTR_W        (QTR_W)
  ) phase_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (rise),
    .cnt_q      (cnt_q),
    .qtr_q      (qtr_q),
    .period_end (period_end)
  );

  cpwm_leg_shaper #(
    .PERIOD_TICKS (PERIOD_TICKS),
    .QTR          (QTR),
    .CNT_W        (CNT_W),
    .QTR_W        (QTR_W),
    .DT_W         (DT_W)
  ) shaper_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .cnt       (cnt_q),
    .qtr       (qtr_q),
    .dt        (dt_q),
    .pwm_hi    (pwm_hi),
    .pwm_lo_n  (pwm_lo_n),
    .demod_clk (demod_clk)
  );

endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker #(
  parameter int PERIOD_TICKS = 20,
  parameter int DT_MAX       = 4,
  parameter int DT_W         = 3,
  parameter int CNT_W        = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             run_q,
  input logic             period_end,
  input logic [CNT_W-1:0] cnt_q,
  input logic [DT_W-1:0]  dt_q,
  input logic             pwm_hi,
  input logic             pwm_lo_n,
  input logic             demod_clk
);

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_hi && !pwm_lo_n)); // R4

  AST_DT_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    dt_q <= DT_W'(DT_MAX)); // R5

  AST_DT_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !rise) |=> $stable(dt_q)); // R6

  AST_RISE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cnt_q == '0)); // R7

  AST_PERIOD_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !period_end) |=> run_q); // R8

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (!pwm_hi && pwm_lo_n)); // R9

  AST_REF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> demod_clk); // R10

endmodule

bind cpwm_burst_driver cpwm_checker #(
  .PERIOD_TICKS (PERIOD_TICKS),
  .DT_MAX       (DT_MAX),
  .DT_W         (DT_W),
  .CNT_W        (CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rise       (rise),
  .run_q      (run_q),
  .period_end (period_end),
  .cnt_q      (cnt_q),
  .dt_q       (dt_q),
  .pwm_hi     (pwm_hi),
  .pwm_lo_n   (pwm_lo_n),
  .demod_clk  (demod_clk)
);

// File: tb/cpwm_burst_driver_tb_top.sv
`timescale 1ns/1ps
module cpwm_burst_driver_tb_top;

  localparam int P    = 20;
  localparam int HALF = P / 2;
  localparam int Q    = P / 4;
  localparam int DMAX = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_en = 1'b0;
  logic [2:0] dead_ticks = 3'd0;
  logic       pwm_hi, pwm_lo_n, demod_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R9";

  // Tick-count model of the requirements.
  int m_cnt = 0, m_dt = 0;
  bit m_run = 0, m_prev_en = 0;
  bit e_hi = 0, e_lon = 1, e_dem = 0;

  always #2 clk = ~clk; // 250 MHz

  cpwm_burst_driver #(.PERIOD_TICKS(P), .DT_MAX(DMAX), .DT_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .dead_ticks(dead_ticks),
    .pwm_hi(pwm_hi), .pwm_lo_n(pwm_lo_n), .demod_clk(demod_clk)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dt = 0; m_run = 0; m_prev_en = 0;
      e_hi = 0; e_lon = 1; e_dem = 0;
    end else begin
      bit start, last;
      // Outputs show the tick the counter held before this edge.
      e_hi  = m_run && (m_cnt >= m_dt) && (m_cnt < HALF);          // R2
      e_lon = !(m_run && (m_cnt >= HALF + m_dt));                   // R3
      e_dem = ((m_cnt % Q) < ((Q + 1) / 2));                        // R10
      start = burst_en && !m_prev_en;                               // R7
      last  = (m_cnt == P - 1);
      if (start || last) m_dt = (int'(dead_ticks) > DMAX) ? DMAX : int'(dead_ticks); // R5 R6
      if (start) m_run = 1;
      else if (last && !burst_en) m_run = 0;                        // R8
      m_cnt = (start || last) ? 0 : m_cnt + 1;
      m_prev_en = burst_en;
    end
  end

  task automatic chk(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual %b expected %b", req, tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pwm_hi", pwm_hi, e_hi);
      chk("R3 pwm_lo_n", pwm_lo_n, e_lon);
      chk("R10 demod_clk", demod_clk, e_dem);
      chk("R4 no overlap", pwm_hi && !pwm_lo_n, 1'b0);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    tag = "R1";
    chk("R1 reset pwm_hi", pwm_hi, 1'b0);
    chk("R1 reset pwm_lo_n", pwm_lo_n, 1'b1);
    chk("R1 reset demod_clk", demod_clk, 1'b0);
    rst_n = 1'b1;
    tag = "R9";
    wait_cyc(30);
    for (int d = 0; d < 8; d++) begin
      tag = (d > DMAX) ? "R5" : "R2";
      dead_ticks = 3'(d);
      burst_en = 1'b1;
      wait_cyc(3 * P + 7);
      tag = "R8";
      burst_en = 1'b0;
      wait_cyc(2 * P);
    end
    tag = "R6";
    dead_ticks = 3'd1;
    burst_en = 1'b1;
    wait_cyc(P + 5);
    dead_ticks = 3'd3;
    wait_cyc(2 * P);
    burst_en = 1'b0;
    wait_cyc(2 * P);
    tag = "R7";
    dead_ticks = 3'd2;
    burst_en = 1'b1;
    wait_cyc(P + 7);
    burst_en = 1'b0;
    wait_cyc(2);
    burst_en = 1'b1;
    wait_cyc(2 * P + 5);
    burst_en = 1'b0;
    tag = "R9";
    wait_cyc(2 * P);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule